// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block sends bytes over a clocked serial link made of a data line and a clock line. It has two byte registers. Software writes a byte into a holding register. The byte then moves into a shift register, which sends it out one bit at a time, least significant bit first. A flag reports when the holding register can take another byte. If software writes a new byte each time the flag rises, one byte follows the next with no idle clock between them.

One control bit picks who owns the clock. In master mode the block makes the clock by dividing the system clock, with a 4-bit divide setting, and drives it out. In slave mode it samples an external clock through a two-flop synchronizer and acts on the edges it detects. In both modes the data line changes only after a falling clock edge. It is therefore stable when the clock rises, which is when the receiver samples it.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, `sck_out` is 1, `sdo` is 1 and `tx_empty` is 0.
- R2: While `en` is 0, writes are ignored, no clock edges are produced, `sck_out` and `sdo` stay at 1 and `tx_empty` is 0 from the next cycle on.
- R3: With `en` at 1, when `tx_sel` is 1 and the block is not yet in transmit mode, the block enters transmit mode and `tx_empty` reads 1 in the next cycle.
- R4: A write is accepted when `wr_valid` is 1 and `en`, `tx_sel`, transmit mode and `tx_empty` are all 1. An accepted write makes `tx_empty` 0 in the next cycle. When the byte moves into the shift register, `tx_empty` returns to 1. If the shifter is idle, this happens one cycle later.
- R5: A write while `tx_empty` is 0 is ignored. It is not sent and it does not overwrite the queued byte.
- R6: Each byte is sent least significant bit first, as bits 0 to 7, with eight clock periods per byte. `sdo` changes only after a falling clock edge and never at a rising edge.
- R7: When `master` is 1, `sck_oe` is 1 and each clock half-period lasts `clk_div`+1 system cycles. The first falling edge comes `clk_div`+1 cycles after the byte is loaded.
- R8: If a new byte is queued before the current byte ends, it starts straight after the eighth rising edge. The rising edges stay exactly 2*(`clk_div`+1) cycles apart across the byte boundary.
- R9: When `master` is 0, `sck_oe` is 0 and the block follows `ext_sck`. `sdo` takes the next bit three system cycles after a falling edge of `ext_sck`.
- R10: Clearing `tx_sel` while `tx_empty` is 0 does not leave transmit mode at once. Queued bytes are still sent. Transmit mode ends once `tx_empty` is 1, after which `tx_empty` reads 0 and writes are ignored.
- R11: After the last byte, if nothing is queued, the clock stays high and `sdo` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transfer enable; when 0, the engine is held cleared |
| master | input | 1 | 1: drive the clock out; 0: use `ext_sck` |
| tx_sel | input | 1 | Transmit-mode select |
| clk_div | input | 4 | Half-period of the generated clock, minus one, in system cycles |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| ext_sck | input | 1 | External transfer clock used in slave mode |
| sck_out | output | 1 | Generated transfer clock; idles high |
| sck_oe | output | 1 | Output enable for the clock pin |
| sdo | output | 1 | Serial data output |
| tx_empty | output | 1 | Holding register can accept a byte |

## Verification
The bench sends single bytes with alternating and asymmetric bit patterns (A5, 3C, 81, 7E, 00, FF), so that a reversed bit order or a misplaced bit gives a different received byte. It uses three divide settings, which show whether the half-period follows `clk_div`. It also sends runs of bytes written as soon as `tx_empty` rises, where checking the spacing of rising edges tells a gapless handover from one that inserts an idle cycle. In slave mode, a byte starting with a 0 bit separates correct timing of the synchronized falling edge from an early or late data update. The bench also tries writes while the flag is low, writes while the block is disabled, and a transmit-select drop during a queued transfer. These show whether ignored stimulus leaks onto the line.

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic             tx_sel,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             ext_sck,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             sdo,
  output logic             tx_empty
);

  logic             tx_mode, hold_full, busy, phase, sck_q, last_q;
  logic [7:0]       hold_q, shift_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] cnt_q;
  logic [1:0]       sync_q;

  wire wr_ok    = en && tx_mode && tx_sel && tx_empty && wr_valid;
  wire tick     = (cnt_q == clk_div);
  wire ext_fall = last_q && !sync_q[1];
  wire ext_rise = !last_q && sync_q[1];
  wire fall_ev  = busy && !phase && (master ? tick : ext_fall);
  wire rise_ev  = busy && phase && (master ? tick : ext_rise);
  wire byte_end = rise_ev && (bit_q == 3'd7);
  wire load     = en && hold_full && (!busy || byte_end);

  assign sck_out = master ? sck_q : 1'b1;
  assign sck_oe  = master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], ext_sck};
      last_q <= sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_mode   <= 1'b0;
      tx_empty  <= 1'b0;
      hold_full <= 1'b0;
      hold_q    <= '0;
      shift_q   <= '0;
      busy      <= 1'b0;
      phase     <= 1'b0;
      bit_q     <= '0;
      cnt_q     <= '0;
      sck_q     <= 1'b1;
      sdo       <= 1'b1;
    end else if (!en) begin
      tx_mode   <= 1'b0;
      tx_empty  <= 1'b0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      phase     <= 1'b0;
      bit_q     <= '0;
      cnt_q     <= '0;
      sck_q     <= 1'b1;
      sdo       <= 1'b1;
    end else begin
      if (tx_sel && !tx_mode) begin
        tx_mode  <= 1'b1;
        tx_empty <= 1'b1;
      end else if (!tx_sel && tx_mode && tx_empty) begin
        tx_mode  <= 1'b0;
        tx_empty <= 1'b0;
      end

      if (wr_ok) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
        tx_empty  <= 1'b0;
      end

      if (busy && master)
        cnt_q <= tick ? '0 : cnt_q + 1'b1;

      if (fall_ev) begin
        sck_q   <= 1'b0;
        sdo     <= shift_q[0];
        shift_q <= {1'b0, shift_q[7:1]};
        phase   <= 1'b1;
      end

      if (rise_ev) begin
        sck_q <= 1'b1;
        phase <= 1'b0;
        bit_q <= bit_q + 3'd1;
        if (byte_end)
          busy <= 1'b0;
      end

      if (load) begin
        shift_q   <= hold_q;
        hold_full <= 1'b0;
        tx_empty  <= 1'b1;
        busy      <= 1'b1;
        phase     <= 1'b0;
        bit_q     <= '0;
        cnt_q     <= '0;
      end

      if (!busy && !hold_full) begin
        sdo   <= 1'b1;
        sck_q <= 1'b1;
      end
    end
  end

endmodule

module sync_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic master,
  input logic tx_sel,
  input logic wr_valid,
  input logic sck_out,
  input logic sdo,
  input logic tx_empty,
  input logic tx_mode,
  input logic busy
);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sck_out && sdo && !tx_empty));

  assert_enter_sets_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_sel && !tx_mode) |=> tx_empty);

  assert_write_clears_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_mode && tx_sel && tx_empty && wr_valid) |=> !tx_empty);

  assert_data_stable_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && $rose(sck_out)) |-> $stable(sdo));

  assert_idle_clock_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> sck_out);

endmodule

bind sync_ser_tx sync_ser_tx_chk u_chk (.*);

// File: tb/sync_ser_tx_test.sv
`timescale 1ns/1ps
module sync_ser_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, master = 1'b1, tx_sel = 1'b0, wr_valid = 1'b0, ext_sck = 1'b1;
  logic [3:0] clk_div = 4'd1;
  logic [7:0] wr_data = '0;
  logic       sck_out, sck_oe, sdo, tx_empty;

  sync_ser_tx uut (.*);

  always #2.5 clk = ~clk;

  int   errors = 0, checks = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] shreg = '0;
  int   nbits = 0;
  logic line_prev = 1'b1;
  bit   gap_on = 1'b0;
  int   last_rise = -1, period = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: sample sdo on each rising clock edge and compare bytes in order
  always @(negedge clk) begin
    logic line;
    line = sck_oe ? sck_out : ext_sck;
    if (rst_n && !line_prev && line) begin
      if (gap_on) begin
        if (last_rise >= 0) chk(cyc - last_rise == period, "R8 edge spacing", cyc - last_rise, period);
        last_rise = cyc;
      end
      shreg = {sdo, shreg[7:1]};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        if (exp_q.size() == 0) chk(1'b0, "R5/R6 unexpected byte", shreg, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(shreg == e, "R6 byte", shreg, e);
        end
      end
    end
    line_prev = line;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] b, input bit idle);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = b;
    step(1);
    wr_valid = 1'b0;
    exp_q.push_back(b);
    chk(tx_empty == 1'b0, "R4 empty cleared", tx_empty, 0);
    if (idle) begin
      step(1);
      chk(tx_empty == 1'b1, "R4 empty after load", tx_empty, 1);
    end
  endtask

  task automatic poke(input logic [7:0] b);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = b;
    step(1);
    wr_valid = 1'b0;
  endtask

  task automatic wait_empty();
    while (!tx_empty) step(1);
  endtask

  task automatic drain(input int n);
    step(n);
    chk(exp_q.size() == 0, "R6 all bytes sent", exp_q.size(), 0);
  endtask

  initial begin
    step(3);
    chk(sck_out == 1'b1 && sdo == 1'b1 && tx_empty == 1'b0, "R1 reset", {sck_out, sdo, tx_empty}, 3'b110);
    rst_n = 1'b1;
    step(2);

    // R2: disabled block ignores everything
    tx_sel = 1'b1;
    poke(8'h99);
    step(20);
    chk(tx_empty == 1'b0, "R2 empty stays 0", tx_empty, 0);
    chk(sck_out == 1'b1 && sdo == 1'b1, "R2 line idle", {sck_out, sdo}, 2'b11);

    // R3: enabling with tx_sel already high enters transmit mode
    en = 1'b1;
    step(1);
    chk(tx_empty == 1'b1, "R3 empty on entry", tx_empty, 1);
    chk(sck_oe == 1'b1, "R7 clock driven in master", sck_oe, 1);

    // single bytes, divide 1 and 0
    put(8'hA5, 1'b1);
    drain(60);
    clk_div = 4'd0;
    put(8'h3C, 1'b1);
    put(8'h5A, 1'b0);
    poke(8'hFF);
    chk(tx_empty == 1'b0, "R5 empty still 0 after ignored write", tx_empty, 0);
    drain(80);

    // R8: gapless stream with divide 2
    clk_div = 4'd2; period = 6; last_rise = -1; gap_on = 1'b1;
    put(8'h81, 1'b1);
    wait_empty(); put(8'h7E, 1'b0);
    wait_empty(); put(8'h00, 1'b0);
    wait_empty(); put(8'hFF, 1'b0);
    drain(120);
    gap_on = 1'b0;

    // R11: idle after last byte
    chk(sck_out == 1'b1 && sdo == 1'b1, "R11 idle line", {sck_out, sdo}, 2'b11);
    step(10);
    chk(sck_out == 1'b1, "R11 clock stays high", sck_out, 1);

    // R10: drop tx_sel with a byte queued
    clk_div = 4'd1;
    put(8'h11, 1'b1);
    put(8'h22, 1'b0);
    tx_sel = 1'b0;
    step(1);
    chk(tx_empty == 1'b0, "R10 still queued", tx_empty, 0);
    drain(100);
    chk(tx_empty == 1'b0, "R10 mode left", tx_empty, 0);
    poke(8'h44);
    step(60);
    chk(exp_q.size() == 0 && sck_out == 1'b1, "R10 write ignored after leaving", exp_q.size(), 0);

    // R9: slave mode with external clock
    master = 1'b0;
    tx_sel = 1'b1;
    step(1);
    chk(tx_empty == 1'b1, "R3 re-entry", tx_empty, 1);
    chk(sck_oe == 1'b0, "R9 clock not driven", sck_oe, 0);
    put(8'h96, 1'b1);
    put(8'hC3, 1'b0);
    for (int i = 0; i < 16; i++) begin
      ext_sck = 1'b0;
      if (i == 0) begin
        step(2);
        chk(sdo == 1'b1, "R9 no early update", sdo, 1);
        step(1);
        chk(sdo == 1'b0, "R9 bit0 after sync", sdo, 0);
        step(3);
      end else step(6);
      ext_sck = 1'b1;
      step(6);
    end
    drain(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule